// File: doc/BRIEF.md
# Receiver Error Capture and Sample Concealment

This block sits behind the decoder of a digital audio interface receiver and gathers its per-frame error strobes into one register. The strobes cover seven conditions:

- loss of lock in the clock-recovery loop,
- a validity flag,
- a low-confidence eye opening,
- a bi-phase coding violation,
- a parity failure,
- a checksum failure on the subcode data,
- a checksum failure on the channel-status data.

A per-bit enable mask decides which of these conditions count. Each enabled error sets a sticky bit, produces a one-cycle error pulse and raises the interrupt. An enabled error can also conceal the audio sample received in the same cycle.

The concealment policy is chosen at run time. The block can repeat the last good sample, substitute silence, or let the sample pass unchanged. Checksum failures are logged like the other errors, but they never touch the audio. A host read returns the register contents and clears them. An error that arrives in the same cycle as the read is kept for the next read.

Top module: `rx_err_monitor`

## Requirements
- R1: Error vector bit positions are 0 unlock, 1 validity, 2 low confidence, 3 bi-phase, 4 parity, 5 subcode checksum, 6 channel-status checksum. An enabled error sets its sticky bit on the next clock, and the bit stays set until a read clears it.
- R2: When `rd_en` is high, `rd_data` shows the sticky register on the next clock, as it stood before that edge. After that edge the register holds only the enabled errors that arrived in the read cycle.
- R3: An error whose `err_mask` bit is 0 does not set its sticky bit, does not pulse `err_pulse` and does not change the audio output.
- R4: `err_pulse` is high for exactly the cycle after a cycle with at least one enabled error.
- R5: `irq` is high whenever any sticky bit is set, and low otherwise.
- R6: For a sample that coincides with an enabled audio-class error (bits 0 to 4), the output depends on `hold_mode`. Mode 0 outputs the held previous sample. Mode 1 outputs zero. Modes 2 and 3 pass the input unchanged.
- R7: Checksum errors (bits 5 and 6) never modify the sample, even when they are enabled.
- R8: The held previous sample resets to zero. It loads only from samples that carry no enabled audio-class error.
- R9: After reset, `rd_data`, `err_pulse`, `irq`, `smp_vld` and `smp_out` are all zero.
- R10: Every sample with `smp_in_vld` high appears on `smp_out` with `smp_vld` high exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_in | input | 7 | Error strobes from decoder and lock detector |
| err_mask | input | 7 | Per-bit enable, 1 = error counts |
| hold_mode | input | 2 | Concealment policy: 0 repeat, 1 zero, 2/3 pass |
| smp_in_vld | input | 1 | Audio sample present this cycle |
| smp_in | input | SMP_W | Audio sample |
| rd_en | input | 1 | Host read and clear strobe |
| rd_data | output | 7 | Captured register value |
| err_pulse | output | 1 | One-cycle pulse per cycle with enabled errors |
| irq | output | 1 | Interrupt, any sticky bit set |
| smp_vld | output | 1 | Output sample valid |
| smp_out | output | SMP_W | Concealed output sample |

## Verification
The first stimulus is a directed sequence. It sends a lone validity error in each hold mode, so repeat, zero and pass are told apart against a known previous sample. The same sequence sends an enabled checksum-only error to separate checksum-class errors from audio-class errors. It also sends a masked error, which should leave audio and the register untouched. A read with an error in the same cycle checks the clear-versus-set ordering. A long pseudo-random phase then varies errors, mask, mode and reads together, and a cycle-level model is compared against every output on every clock.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    localparam int NERR = 7;

    localparam int E_UNLOCK = 0;
    localparam int E_VALID  = 1;
    localparam int E_CONF   = 2;
    localparam int E_BIP    = 3;
    localparam int E_PAR    = 4;
    localparam int E_QCRC   = 5;
    localparam int E_CCRC   = 6;

    typedef logic [NERR-1:0] errvec_t;

    // Errors that are allowed to trigger concealment.
    localparam errvec_t AUDIO_CLASS = errvec_t'((1 << E_UNLOCK) | (1 << E_VALID) |
                                                (1 << E_CONF)   | (1 << E_BIP)   |
                                                (1 << E_PAR));

    typedef enum logic [1:0] {
        HOLD_REPEAT = 2'd0,
        HOLD_ZERO   = 2'd1,
        HOLD_PASS   = 2'd2,
        HOLD_PASS2  = 2'd3
    } hold_e;

    typedef struct packed {
        errvec_t enabled;
        logic    any_hit;
        logic    audio_hit;
    } gate_t;

    function automatic logic hits_audio(errvec_t e);
        return |(e & AUDIO_CLASS);
    endfunction

endpackage

// File: rtl/rxerr_gate.sv
module rxerr_gate
    import rxerr_pkg::*;
(
    input  errvec_t err_in,
    input  errvec_t err_mask,
    output gate_t   gate
);
    errvec_t en_v;

    genvar i;
    generate
        for (i = 0; i < NERR; i++) begin : g_bit
            assign en_v[i] = err_in[i] & err_mask[i];
        end
    endgenerate

    always_comb begin
        gate.enabled   = en_v;
        gate.any_hit   = |en_v;
        gate.audio_hit = hits_audio(en_v);
    end
endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky
    import rxerr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  errvec_t set_vec,
    input  logic    set_any,
    input  logic    rd_en,
    output errvec_t rd_data,
    output logic    err_pulse,
    output logic    irq
);
    errvec_t sticky_q;
    errvec_t sticky_base;

    // Read clears what was captured; same-cycle errors survive.
    always_comb sticky_base = rd_en ? '0 : sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q  <= '0;
            rd_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            sticky_q  <= sticky_base | set_vec;
            err_pulse <= set_any;
            if (rd_en) rd_data <= sticky_q;
        end
    end

    assign irq = |sticky_q;
endmodule

// File: rtl/rxerr_conceal.sv
module rxerr_conceal
    import rxerr_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_in_vld,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             audio_hit,
    input  logic [1:0]       hold_mode,
    output logic             smp_vld,
    output logic [SMP_W-1:0] smp_out
);
    logic [SMP_W-1:0] prev_q;
    logic [SMP_W-1:0] pick;
    hold_e            mode;

    assign mode = hold_e'(hold_mode);

    always_comb begin
        pick = smp_in;
        if (audio_hit) begin
            unique case (mode)
                HOLD_REPEAT: pick = prev_q;
                HOLD_ZERO:   pick = '0;
                HOLD_PASS,
                HOLD_PASS2:  pick = smp_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            smp_vld <= 1'b0;
            smp_out <= '0;
        end else begin
            smp_vld <= smp_in_vld;
            if (smp_in_vld) begin
                smp_out <= pick;
                if (!audio_hit) prev_q <= smp_in;
            end
        end
    end
endmodule

// File: rtl/rx_err_monitor.sv
module rx_err_monitor
    import rxerr_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       err_in,
    input  logic [6:0]       err_mask,
    input  logic [1:0]       hold_mode,
    input  logic             smp_in_vld,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             rd_en,
    output logic [6:0]       rd_data,
    output logic             err_pulse,
    output logic             irq,
    output logic             smp_vld,
    output logic [SMP_W-1:0] smp_out
);
    gate_t   gate;
    errvec_t rd_v;

    rxerr_gate u_gate (
        .err_in   (errvec_t'(err_in)),
        .err_mask (errvec_t'(err_mask)),
        .gate     (gate)
    );

    rxerr_sticky u_sticky (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (gate.enabled),
        .set_any   (gate.any_hit),
        .rd_en     (rd_en),
        .rd_data   (rd_v),
        .err_pulse (err_pulse),
        .irq       (irq)
    );

    assign rd_data = rd_v;

    rxerr_conceal #(.SMP_W(SMP_W)) u_conceal (
        .clk        (clk),
        .rst        (rst),
        .smp_in_vld (smp_in_vld),
        .smp_in     (smp_in),
        .audio_hit  (gate.audio_hit),
        .hold_mode  (hold_mode),
        .smp_vld    (smp_vld),
        .smp_out    (smp_out)
    );
endmodule

// File: rtl/rxerr_chk.sv
module rxerr_chk #(
    parameter int SMP_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       err_in,
    input logic [6:0]       err_mask,
    input logic [1:0]       hold_mode,
    input logic             smp_in_vld,
    input logic [SMP_W-1:0] smp_in,
    input logic             rd_en,
    input logic             err_pulse,
    input logic             irq,
    input logic             smp_vld,
    input logic [SMP_W-1:0] smp_out
);
    p_pulse_set_r4: assert property (@(posedge clk) disable iff (rst)
        (|(err_in & err_mask)) |=> err_pulse);

    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !(|(err_in & err_mask)) |=> !err_pulse);

    p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
        (|(err_in & err_mask)) |=> irq);

    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(|(err_in & err_mask))) |=> !irq);

    p_clean_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_in_vld && !(|(err_in & err_mask & 7'b0011111)))
        |=> (smp_vld && smp_out == $past(smp_in)));

    p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_in_vld && (|(err_in & err_mask & 7'b0011111)) && hold_mode == 2'd1)
        |=> (smp_out == '0));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        smp_in_vld |=> smp_vld);
endmodule

bind rx_err_monitor rxerr_chk #(.SMP_W(SMP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .err_in     (err_in),
    .err_mask   (err_mask),
    .hold_mode  (hold_mode),
    .smp_in_vld (smp_in_vld),
    .smp_in     (smp_in),
    .rd_en      (rd_en),
    .err_pulse  (err_pulse),
    .irq        (irq),
    .smp_vld    (smp_vld),
    .smp_out    (smp_out)
);

// File: tb/rx_err_monitor_tb.sv
module rx_err_monitor_tb;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [6:0]   err_in = '0;
    logic [6:0]   err_mask = '0;
    logic [1:0]   hold_mode = '0;
    logic         smp_in_vld = 1'b0;
    logic [W-1:0] smp_in = '0;
    logic         rd_en = 1'b0;
    logic [6:0]   rd_data;
    logic         err_pulse, irq, smp_vld;
    logic [W-1:0] smp_out;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int unsigned  m_sticky = 0, m_rd = 0, m_prev = 0, m_out = 0;
    bit           m_pulse = 0, m_vld = 0;
    string        m_tag = "R8";

    always #5 clk = ~clk;

    rx_err_monitor #(.SMP_W(W)) u_dut (
        .clk(clk), .rst(rst), .err_in(err_in), .err_mask(err_mask),
        .hold_mode(hold_mode), .smp_in_vld(smp_in_vld), .smp_in(smp_in),
        .rd_en(rd_en), .rd_data(rd_data), .err_pulse(err_pulse), .irq(irq),
        .smp_vld(smp_vld), .smp_out(smp_out)
    );

    always @(posedge clk) begin
        int unsigned en;
        bit          aud;
        en  = int'(err_in & err_mask);
        aud = (en & 32'h1F) != 0;
        if (rst) begin
            m_sticky = 0; m_rd = 0; m_prev = 0; m_out = 0;
            m_pulse = 0; m_vld = 0;
        end else begin
            if (rd_en) m_rd = m_sticky;
            m_sticky = (rd_en ? 0 : m_sticky) | en;
            m_pulse  = (en != 0);
            m_vld    = smp_in_vld;
            if (smp_in_vld) begin
                if (!aud) begin
                    m_out = smp_in;
                    m_prev = smp_in;
                    m_tag = ((en & 32'h60) != 0) ? "R7" :
                            ((err_in & ~err_mask) != 0) ? "R3" : "R8";
                end else begin
                    m_tag = "R6";
                    if (hold_mode == 2'd0)      m_out = m_prev;
                    else if (hold_mode == 2'd1) m_out = 0;
                    else                        m_out = smp_in;
                end
            end
        end
    end

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1", rd_data, m_rd);
        chk("R4", err_pulse, m_pulse);
        chk("R5", irq, m_sticky != 0);
        chk("R10", smp_vld, m_vld);
        if (m_vld) chk(m_tag, smp_out, m_out);
    endtask

    // one cycle: drive at negedge, outputs compared at following negedge
    task automatic step(input logic [6:0] e, input logic [6:0] m, input logic [1:0] h,
                        input logic v, input int unsigned s, input logic r);
        err_in = e; err_mask = m; hold_mode = h; smp_in_vld = v;
        smp_in = W'(s); rd_en = r;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(7'h0, 7'h7F, 2'd0, 1'b0, 0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", {rd_data, err_pulse, irq, smp_vld}, 0);
        chk("R9", smp_out, 0);
        rst = 1'b0;
        idle();

        // R8: clean sample becomes previous
        step(7'h0, 7'h7F, 2'd0, 1'b1, 24'h123456, 1'b0);
        chk("R8", smp_out, 24'h123456);
        // R6 repeat: validity error (bit 1)
        step(7'h02, 7'h7F, 2'd0, 1'b1, 24'hABCDEF, 1'b0);
        chk("R6", smp_out, 24'h123456);
        chk("R4", err_pulse, 1);
        // R8: errored sample did not replace previous
        step(7'h02, 7'h7F, 2'd0, 1'b1, 24'h777777, 1'b0);
        chk("R8", smp_out, 24'h123456);
        // R6 zero
        step(7'h02, 7'h7F, 2'd1, 1'b1, 24'h555555, 1'b0);
        chk("R6", smp_out, 0);
        // R6 pass
        step(7'h02, 7'h7F, 2'd2, 1'b1, 24'h444444, 1'b0);
        chk("R6", smp_out, 24'h444444);
        // read: R1 validity bit captured
        step(7'h0, 7'h7F, 2'd0, 1'b0, 0, 1'b1);
        chk("R1", rd_data, 7'h02);
        chk("R5", irq, 0);
        // R7: enabled checksum error with repeat mode passes sample
        step(7'h60, 7'h7F, 2'd0, 1'b1, 24'h0F0F0F, 1'b0);
        chk("R7", smp_out, 24'h0F0F0F);
        chk("R5", irq, 1);
        // R3: masked parity error with zero mode
        step(7'h0, 7'h7F, 2'd0, 1'b0, 0, 1'b1);
        step(7'h10, 7'h6F, 2'd1, 1'b1, 24'h3C3C3C, 1'b0);
        chk("R3", smp_out, 24'h3C3C3C);
        chk("R3", err_pulse, 0);
        chk("R3", irq, 0);
        // R2: error in the read cycle survives the clear
        step(7'h01, 7'h7F, 2'd0, 1'b0, 0, 1'b0);
        step(7'h08, 7'h7F, 2'd0, 1'b0, 0, 1'b1);
        chk("R2", rd_data, 7'h01);
        chk("R2", irq, 1);
        step(7'h0, 7'h7F, 2'd0, 1'b0, 0, 1'b1);
        chk("R2", rd_data, 7'h08);

        // pseudo-random phase
        for (int i = 0; i < 4000; i++) begin
            step(7'($urandom_range(0, 3) == 0 ? $urandom : 0), 7'($urandom),
                 2'($urandom), 1'($urandom), $urandom & 32'hFFFFFF,
                 $urandom_range(0, 7) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule